// File: doc/BRIEF.md
# Two-Level Hardware Page Walker

This block resolves a translation that the TLB could not supply. When a miss is presented, it reads a directory entry from memory and then a table entry. It combines the permission bits of both levels and checks them against the kind of access and the privilege mode. It then returns either a refill record for the TLB or a fault. The access that missed stays stalled for the whole walk, and no exception is raised on a successful walk.

Both entry kinds are 32 bits wide:

| Bits | Meaning |
|------|---------|
| 31:12 | Page number: the page holding the next table, or the final frame |
| 2 | User-allowed |
| 1 | Write-allowed |
| 0 | Present |

Every directory entry governs all 1024 pages of the table it points to, so its permission bits restrict every page of that table.

Memory is reached through a one-cycle read request. The reply is a data word that comes back with a valid strobe after any latency.

Top module: `pt_walker`

## Requirements
- R1: After synchronous reset, `miss_ready` is 1 and `mem_req`, `refill_valid` and `fault_valid` are 0.
- R2: The first read of a walk goes to `dir_base[31:12]*4096 + vaddr[31:22]*4`.
- R3: The second read of a walk goes to `dir_entry[31:12]*4096 + vaddr[21:12]*4`.
- R4: A directory entry with bit 0 clear ends the walk with a fault, `fault_kind` = 0 (not present), and no second read is issued.
- R5: A table entry with bit 0 clear ends the walk with a fault, `fault_kind` = 0.
- R6: A write succeeds only if bit 1 is set in both entries; otherwise the walk ends with a fault, `fault_kind` = 1 (protection). This holds in either privilege mode.
- R7: A user-mode access succeeds only if bit 2 is set in both entries; otherwise the result is a fault with `fault_kind` = 1. A supervisor access ignores bit 2.
- R8: A successful walk pulses `refill_valid` for one cycle with the following values:
  - `refill_vpn` = `vaddr[31:12]`
  - `refill_ppn` = `table_entry[31:12]`
  - `refill_flags[0]` = AND of both bit 1 values
  - `refill_flags[1]` = AND of both bit 2 values
- R9: Each walk ends with exactly one one-cycle pulse of `refill_valid` or `fault_valid`, never both. `miss_ready` is 0 from acceptance until that pulse and is 1 in the cycle after it. A `miss_valid` pulse presented while `miss_ready` is 0 is ignored.
- R10: Each `mem_req` lasts exactly one cycle. The walker waits for `mem_rvalid` for any latency of one cycle or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A TLB miss is presented |
| miss_vaddr | input | 32 | Virtual address that missed |
| miss_write | input | 1 | 1 = write access |
| miss_user | input | 1 | 1 = user mode, 0 = supervisor |
| miss_ready | output | 1 | Walker idle; a miss is accepted this cycle |
| dir_base | input | 32 | Physical base of the directory (bits 31:12 used) |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| refill_valid | output | 1 | Translation found |
| refill_vpn | output | 20 | Virtual page number of the refill |
| refill_ppn | output | 20 | Physical page number of the refill |
| refill_flags | output | 2 | Bit 0 write-allowed, bit 1 user-allowed |
| fault_valid | output | 1 | Walk ended in a fault |
| fault_kind | output | 1 | 0 not present, 1 protection |

## Verification
Directed walks place a missing entry at each level separately, which shows whether the walk stops at the directory or goes on to the table. Other directed walks clear the write or user bit in only one of the two entries, which shows that both levels are combined rather than one alone. Supervisor walks against user-restricted entries confirm that the user bit is ignored in that mode. Random walks vary addresses, bases, flag bits, memory latency and stray miss pulses during a walk; they confirm both read addresses and the refill fields against a reference computed in the bench.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENTRY_W  = 32;
  localparam int BIT_PRES = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_USR  = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_READ_DIR, S_WAIT_DIR, S_READ_PTE, S_WAIT_PTE, S_REFILL, S_FAULT
  } walk_state_t;

  localparam logic KIND_NOT_PRESENT = 1'b0;
  localparam logic KIND_PROTECTION  = 1'b1;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 10
) (
  input  logic [PA_W-PAGE_BITS-1:0] base_page,
  input  logic [IDX_W-1:0]          index,
  output logic [PA_W-1:0]           addr
);
  localparam int PPN_W = PA_W - PAGE_BITS;

  logic [PA_W-1:0] base_full;
  logic [PA_W-1:0] offset;

  always_comb begin
    base_full = {base_page, {PAGE_BITS{1'b0}}};
    offset    = '0;
    offset[IDX_W+1:0] = {index, 2'b00};
    addr      = base_full + offset;
  end

  logic unused_ok;
  assign unused_ok = (PPN_W > 0);
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic [ENTRY_W-1:0] dir_entry,
  input  logic [ENTRY_W-1:0] tbl_entry,
  input  logic               is_write,
  input  logic               is_user,
  output logic               not_present,
  output logic               prot_fault,
  output logic [1:0]         eff_flags
);
  always_comb begin
    eff_flags[0] = dir_entry[BIT_WR]  & tbl_entry[BIT_WR];
    eff_flags[1] = dir_entry[BIT_USR] & tbl_entry[BIT_USR];
    not_present  = ~tbl_entry[BIT_PRES];
    prot_fault   = (is_write & ~eff_flags[0]) | (is_user & ~eff_flags[1]);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 10,
  parameter int PA_W      = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        miss_valid,
  input  logic [2*IDX_W+PAGE_BITS-1:0] miss_vaddr,
  input  logic                        miss_write,
  input  logic                        miss_user,
  output logic                        miss_ready,
  input  logic [PA_W-1:0]             dir_base,
  output logic                        mem_req,
  output logic [PA_W-1:0]             mem_addr,
  input  logic                        mem_rvalid,
  input  logic [ENTRY_W-1:0]          mem_rdata,
  output logic                        refill_valid,
  output logic [2*IDX_W-1:0]          refill_vpn,
  output logic [PA_W-PAGE_BITS-1:0]   refill_ppn,
  output logic [1:0]                  refill_flags,
  output logic                        fault_valid,
  output logic                        fault_kind
);
  localparam int VA_W  = 2*IDX_W + PAGE_BITS;
  localparam int VPN_W = 2*IDX_W;
  localparam int PPN_W = PA_W - PAGE_BITS;

  walk_state_t        state_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q, usr_q;
  logic [ENTRY_W-1:0] pde_q;
  logic [PA_W-1:0]    addr_q;
  logic [PPN_W-1:0]   ppn_q;
  logic [1:0]         flags_q;
  logic               kind_q;

  logic [PA_W-1:0] dir_addr, tbl_addr;
  logic            pte_np, pte_prot;
  logic [1:0]      pte_flags;

  ptw_entry_addr #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_dir_addr (
    .base_page (dir_base[PA_W-1:PAGE_BITS]),
    .index     (miss_vaddr[VA_W-1:VA_W-IDX_W]),
    .addr      (dir_addr)
  );

  ptw_entry_addr #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_tbl_addr (
    .base_page (mem_rdata[PA_W-1:PAGE_BITS]),
    .index     (va_q[PAGE_BITS+IDX_W-1:PAGE_BITS]),
    .addr      (tbl_addr)
  );

  ptw_perm_check u_perm (
    .dir_entry   (pde_q),
    .tbl_entry   (mem_rdata),
    .is_write    (wr_q),
    .is_user     (usr_q),
    .not_present (pte_np),
    .prot_fault  (pte_prot),
    .eff_flags   (pte_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      pde_q   <= '0;
      addr_q  <= '0;
      ppn_q   <= '0;
      flags_q <= '0;
      kind_q  <= KIND_NOT_PRESENT;
    end else begin
      unique case (state_q)
        S_IDLE: if (miss_valid) begin
          va_q    <= miss_vaddr;
          wr_q    <= miss_write;
          usr_q   <= miss_user;
          addr_q  <= dir_addr;
          state_q <= S_READ_DIR;
        end
        S_READ_DIR: state_q <= S_WAIT_DIR;
        S_WAIT_DIR: if (mem_rvalid) begin
          pde_q <= mem_rdata;
          if (!mem_rdata[BIT_PRES]) begin
            kind_q  <= KIND_NOT_PRESENT;
            state_q <= S_FAULT;
          end else begin
            addr_q  <= tbl_addr;
            state_q <= S_READ_PTE;
          end
        end
        S_READ_PTE: state_q <= S_WAIT_PTE;
        S_WAIT_PTE: if (mem_rvalid) begin
          ppn_q   <= mem_rdata[PA_W-1:PAGE_BITS];
          flags_q <= pte_flags;
          if (pte_np) begin
            kind_q  <= KIND_NOT_PRESENT;
            state_q <= S_FAULT;
          end else if (pte_prot) begin
            kind_q  <= KIND_PROTECTION;
            state_q <= S_FAULT;
          end else begin
            state_q <= S_REFILL;
          end
        end
        S_REFILL: state_q <= S_IDLE;
        S_FAULT:  state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign miss_ready   = (state_q == S_IDLE);
  assign mem_req      = (state_q == S_READ_DIR) || (state_q == S_READ_PTE);
  assign mem_addr     = addr_q;
  assign refill_valid = (state_q == S_REFILL);
  assign refill_vpn   = va_q[VA_W-1:VA_W-VPN_W];
  assign refill_ppn   = ppn_q;
  assign refill_flags = flags_q;
  assign fault_valid  = (state_q == S_FAULT);
  assign fault_kind   = kind_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic       clk,
  input logic       rst,
  input logic       miss_valid,
  input logic       miss_write,
  input logic       miss_user,
  input logic       miss_ready,
  input logic       mem_req,
  input logic       refill_valid,
  input logic [1:0] refill_flags,
  input logic       fault_valid
);
  logic seen_wr, seen_usr;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_wr  <= 1'b0;
      seen_usr <= 1'b0;
    end else if (miss_valid && miss_ready) begin
      seen_wr  <= miss_write;
      seen_usr <= miss_user;
    end
  end

  p_single_end_r9: assert property (@(posedge clk) disable iff (rst)
    !(refill_valid && fault_valid));
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |=> !miss_ready);
  p_ready_after_end_r9: assert property (@(posedge clk) disable iff (rst)
    (refill_valid || fault_valid) |=> miss_ready);
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  p_write_allowed_r6: assert property (@(posedge clk) disable iff (rst)
    (refill_valid && seen_wr) |-> refill_flags[0]);
  p_user_allowed_r7: assert property (@(posedge clk) disable iff (rst)
    (refill_valid && seen_usr) |-> refill_flags[1]);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    miss_ready |-> !(mem_req || refill_valid || fault_valid));
endmodule

bind pt_walker ptw_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .miss_valid   (miss_valid),
  .miss_write   (miss_write),
  .miss_user    (miss_user),
  .miss_ready   (miss_ready),
  .mem_req      (mem_req),
  .refill_valid (refill_valid),
  .refill_flags (refill_flags),
  .fault_valid  (fault_valid)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        miss_valid = 1'b0, miss_write = 1'b0, miss_user = 1'b0;
  logic [31:0] miss_vaddr = '0, dir_base = '0;
  logic        miss_ready, mem_req, refill_valid, fault_valid, fault_kind;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic [19:0] refill_vpn, refill_ppn;
  logic [1:0]  refill_flags;

  pt_walker dut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .miss_write(miss_write), .miss_user(miss_user), .miss_ready(miss_ready),
    .dir_base(dir_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .refill_valid(refill_valid),
    .refill_vpn(refill_vpn), .refill_ppn(refill_ppn), .refill_flags(refill_flags),
    .fault_valid(fault_valid), .fault_kind(fault_kind)
  );

  // memory model
  logic [31:0] mem [logic [31:0]];
  logic [31:0] req_log [$];
  int          lat = 1;
  int          cnt = 0;
  logic [31:0] raddr = '0;
  logic        rv = 1'b0;
  logic [31:0] rd = '0;
  assign mem_rvalid = rv;
  assign mem_rdata  = rd;

  function automatic logic [31:0] mem_get(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cnt <= 0; rv <= 1'b0;
    end else begin
      rv <= 1'b0;
      if (mem_req) begin
        cnt <= lat; raddr <= mem_addr; req_log.push_back(mem_addr);
      end else if (cnt > 1) cnt <= cnt - 1;
      else if (cnt == 1) begin
        cnt <= 0; rv <= 1'b1; rd <= mem_get(raddr);
      end
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected outcome: 0 refill, 1 not present, 2 protection
  function automatic int expect_kind(logic [31:0] pde, logic [31:0] pte, logic wr, logic usr);
    if (!pde[0]) return 1;
    if (!pte[0]) return 1;
    if (wr && !(pde[1] && pte[1])) return 2;
    if (usr && !(pde[2] && pte[2])) return 2;
    return 0;
  endfunction

  task automatic walk(logic [31:0] va, logic [31:0] base, logic [31:0] pde,
                      logic [31:0] pte, logic wr, logic usr, int l, bit stray);
    logic [31:0] daddr, taddr;
    int n0, k, waited;
    daddr = {base[31:12], 12'h0} + {20'h0, va[31:22], 2'b00};
    taddr = {pde[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
    mem.delete();
    mem[daddr] = pde;
    if (pde[0]) mem[taddr] = pte;
    k = expect_kind(pde, pte, wr, usr);
    lat = l;
    @(negedge clk);
    n0 = req_log.size();
    miss_vaddr = va; dir_base = base; miss_write = wr; miss_user = usr;
    miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    chk("R9 busy after accept", {31'h0, miss_ready}, 32'h0);
    if (stray) begin
      miss_vaddr = ~va; miss_write = ~wr; miss_user = ~usr; miss_valid = 1'b1;
      @(negedge clk);
      miss_valid = 1'b0;
    end
    waited = 0;
    while (!(refill_valid || fault_valid) && waited < 60) begin
      @(negedge clk); waited++;
    end
    chk("R9 both pulses", {31'h0, refill_valid && fault_valid}, 32'h0);
    chk("R2 dir read addr", (req_log.size() > n0) ? req_log[n0] : 32'hDEAD_BEEF, daddr);
    if (k == 0) begin
      chk("R8 refill_valid", {31'h0, refill_valid}, 32'h1);
      chk("R8 vpn", {12'h0, refill_vpn}, {12'h0, va[31:12]});
      chk("R8 ppn", {12'h0, refill_ppn}, {12'h0, pte[31:12]});
      chk("R8 flags", {30'h0, refill_flags}, {30'h0, pde[2] & pte[2], pde[1] & pte[1]});
    end else begin
      chk(k == 2 ? "R6/R7 protection fault" : "R4/R5 not-present fault",
          {31'h0, fault_valid}, 32'h1);
      chk("R6/R7 fault kind", {31'h0, fault_kind}, (k == 2) ? 32'h1 : 32'h0);
    end
    if (pde[0]) chk("R3 table read addr", (req_log.size() > n0 + 1) ? req_log[n0+1] : 32'hDEAD_BEEF, taddr);
    chk(pde[0] ? "R10 two reads" : "R4 single read", req_log.size() - n0, pde[0] ? 2 : 1);
    @(negedge clk);
    chk("R9 ready after end", {29'h0, miss_ready, refill_valid, fault_valid}, 32'h4);
  endtask

  initial begin
    void'($urandom(32'd4471));
    repeat (3) @(negedge clk);
    chk("R1 reset state", {28'h0, miss_ready, mem_req, refill_valid, fault_valid}, 32'h8);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {28'h0, miss_ready, mem_req, refill_valid, fault_valid}, 32'h8);
    // directed corner cases
    walk(32'h1234_5678, 32'h0004_0000, 32'h0008_8007, 32'h000A_B007, 1, 1, 1, 0); // R8 full access
    walk(32'hFFC0_1000, 32'h0004_0000, 32'h0008_8006, 32'h000A_B007, 0, 0, 2, 0); // R4
    walk(32'h0040_2000, 32'h0010_0000, 32'h0020_0007, 32'h0030_0006, 0, 0, 1, 0); // R5
    walk(32'h0040_2000, 32'h0010_0000, 32'h0020_0007, 32'h0030_0005, 1, 0, 3, 0); // R6 table RO
    walk(32'h0040_2000, 32'h0010_0000, 32'h0020_0005, 32'h0030_0007, 1, 0, 1, 0); // R6 dir RO
    walk(32'h0040_2000, 32'h0010_0000, 32'h0020_0003, 32'h0030_0007, 0, 1, 1, 0); // R7 dir sup
    walk(32'h0040_2000, 32'h0010_0000, 32'h0020_0007, 32'h0030_0003, 0, 1, 2, 0); // R7 table sup
    walk(32'h0040_2000, 32'h0010_0000, 32'h0020_0003, 32'h0030_0001, 0, 0, 1, 0); // R7 supervisor
    walk(32'h0000_0000, 32'h0000_0000, 32'h0000_1001, 32'h0000_2003, 0, 0, 6, 1); // R10 long latency
    // random walks
    for (int i = 0; i < 80; i++) begin
      logic [31:0] va, base, pde, pte;
      va   = $urandom;
      base = $urandom;
      pde  = $urandom;
      pte  = $urandom;
      if (pde[31:12] == base[31:12]) pde[31] = ~pde[31];
      if (($urandom % 8) != 0) pde[0] = 1'b1;
      if (($urandom % 8) != 0) pte[0] = 1'b1;
      walk(va, base, pde, pte, 1'($urandom), 1'($urandom), 1 + int'($urandom % 5), 1'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule